// File: doc/BRIEF.md
# Vector Register Index Expansion Sequencer

This block takes one decoded instruction that names up to three register operands and turns it into a stream of element operations. All registers share one flat physical index space of 128 entries. Integer names x1..x31 occupy indices 1..31. Floating-point names f0..f31 occupy indices 32..63. Indices 64..127 can only be reached by redirecting an operand to a physical base index.

Any operand may be flagged as redirected and given a base index. The instruction then expands into `vl` element operations. On element `i`, every redirected operand, source or destination, uses index `base+i`. Operands that are not redirected keep their scalar index on every element. A run can climb from the integer range into the floating-point range with no special handling.

Element operations leave through a valid/ready handshake. A new instruction is taken only after the previous one has fully drained. If a redirected operand would step past index 127, the block raises a one-cycle error instead of emitting that element, and it abandons the rest of that instruction.

Top module: `vxs_expander`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_err` is 0.
- R2: A non-redirected operand with type bit 0 (integer) and name N maps to index N. With type bit 1 (floating point) and name N it maps to index 32+N.
- R3: A redirected operand with a non-zero base B yields index B+i on element i. A run starting at 30 with vl=4 gives 30, 31, 32, 33.
- R4: All redirected operands of one instruction use the same element offset, and `out_elem` carries that offset, counting 0, 1, 2, … across successive handoffs.
- R5: A non-redirected operand shows the same index on every element of its instruction.
- R6: An instruction with at least one redirected operand and vl=0 emits no element, and `in_ready` is 1 again on the next cycle.
- R7: An instruction with no redirected operand emits exactly one element with `out_elem`=0 and `out_last`=1, whatever vl is.
- R8: If element i would give some redirected operand with non-zero base an index above 127, elements 0..i-1 are emitted normally. In place of element i, `out_err` is 1 for exactly one cycle with `out_valid` 0. The block then returns to accepting instructions.
- R9: A redirected operand with base 0 shows index 0 on every element (the hardwired zero register is never incremented).
- R10: `in_ready` stays 0 from acceptance until the cycle after the last element is handed off or the error cycle. While `out_valid` is 1 and `out_ready` is 0, the element outputs hold steady.
- R11: `out_last` is 1 on the final element of a full expansion (element vl-1, or the single element of R7) and 0 on earlier elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle; instruction accepted when both high |
| in_vl | input | VL_W | Vector length |
| in_fp | input | NOPS | Per operand: 1 = floating-point name, 0 = integer |
| in_arch | input | NOPS*ARCH_W | Per operand architectural name, operand g at [g*ARCH_W +: ARCH_W] |
| in_redir | input | NOPS | Per operand: 1 = redirected to a base index |
| in_base | input | NOPS*IDX_W | Per operand base physical index |
| out_valid | output | 1 | Element operation offered |
| out_ready | input | 1 | Consumer takes element when both high |
| out_idx | output | NOPS*IDX_W | Per operand physical index of current element |
| out_elem | output | VL_W | Element offset of current element |
| out_last | output | 1 | Current element is the final one |
| out_err | output | 1 | Illegal-index pulse; instruction abandoned |

## Verification
A wrong element counter shows up on the very next handoff as an offset that breaks the 0, 1, 2 stride on `out_elem`, or as redirected indices that stop tracking base plus offset. An error in the overflow compare shows up within one cycle of reaching the 127 boundary, either as a spurious `out_err` or as an index that wraps to a low value. A sequencer stuck in the wrong state shows up as `in_ready` failing to return after the expected number of handoffs. Random back-pressure on `out_ready` checks that held elements do not move.

// File: rtl/vxs_pkg.sv
package vxs_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } vxs_state_e;
endpackage

// File: rtl/vxs_idx_map.sv
module vxs_idx_map #(
   parameter int ARCH_W = 5,
   parameter int IDX_W  = 7
) (
   input  logic              is_fp,
   input  logic [ARCH_W-1:0] arch,
   output logic [IDX_W-1:0]  phys
);
   localparam int FP_OFS = 1 << ARCH_W;

   generate
      if (IDX_W < ARCH_W + 1) begin : g_bad_width
         $error("vxs_idx_map: index space too small for two register banks");
      end
   endgenerate

   always_comb begin
      if (is_fp) phys = IDX_W'(FP_OFS) + IDX_W'(arch);
      else       phys = IDX_W'(arch);
   end
endmodule

// File: rtl/vxs_elem_gen.sv
module vxs_elem_gen #(
   parameter int IDX_W = 7,
   parameter int VL_W  = 7
) (
   input  logic             redir,
   input  logic [IDX_W-1:0] base,
   input  logic [IDX_W-1:0] scalar_idx,
   input  logic [VL_W-1:0]  elem,
   output logic [IDX_W-1:0] idx,
   output logic             ovf
);
   localparam int NREG  = 1 << IDX_W;
   localparam int SUM_W = ((IDX_W > VL_W) ? IDX_W : VL_W) + 1;

   logic [SUM_W-1:0] sum;
   logic             base_zero;

   assign base_zero = (base == '0);
   assign sum       = SUM_W'(base) + SUM_W'(elem);

   always_comb begin
      ovf = redir && !base_zero && (sum > SUM_W'(NREG - 1));
      if (!redir)         idx = scalar_idx;
      else if (base_zero) idx = '0;
      else                idx = sum[IDX_W-1:0];
   end
endmodule

// File: rtl/vxs_seq_ctrl.sv
module vxs_seq_ctrl
   import vxs_pkg::*;
#(
   parameter int VL_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [VL_W-1:0] count,
   input  logic            any_ovf,
   input  logic            out_ready,
   output logic            in_ready,
   output logic [VL_W-1:0] elem,
   output logic            out_valid,
   output logic            out_last,
   output logic            out_err
);
   vxs_state_e      state;
   logic [VL_W-1:0] cnt_q;

   assign in_ready  = (state == SEQ_IDLE);
   assign out_last  = (elem == cnt_q - VL_W'(1));
   assign out_valid = (state == SEQ_RUN) && !any_ovf;
   assign out_err   = (state == SEQ_RUN) && any_ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         elem  <= '0;
         cnt_q <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (in_valid && count != '0) begin
                  state <= SEQ_RUN;
                  elem  <= '0;
                  cnt_q <= count;
               end
            end
            SEQ_RUN: begin
               if (any_ovf) begin
                  state <= SEQ_IDLE;
               end else if (out_ready) begin
                  if (out_last) state <= SEQ_IDLE;
                  else          elem  <= elem + VL_W'(1);
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_ELEM_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> (elem == $past(elem) + VL_W'(1))); // R4
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |=> (!out_err && in_ready)); // R8
   AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> !out_valid); // R8
   AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> in_ready); // R10
endmodule

// File: rtl/vxs_expander.sv
module vxs_expander
   import vxs_pkg::*;
#(
   parameter int NOPS   = 3,
   parameter int ARCH_W = 5,
   parameter int IDX_W  = 7,
   parameter int VL_W   = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [VL_W-1:0]        in_vl,
   input  logic [NOPS-1:0]        in_fp,
   input  logic [NOPS*ARCH_W-1:0] in_arch,
   input  logic [NOPS-1:0]        in_redir,
   input  logic [NOPS*IDX_W-1:0]  in_base,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [NOPS*IDX_W-1:0]  out_idx,
   output logic [VL_W-1:0]        out_elem,
   output logic                   out_last,
   output logic                   out_err
);
   generate
      if (NOPS < 1) begin : g_bad_nops
         $error("vxs_expander: need at least one operand");
      end
      if (VL_W < 1) begin : g_bad_vl
         $error("vxs_expander: vector length width must be positive");
      end
   endgenerate

   logic                  accept;
   logic [VL_W-1:0]       count;
   logic [NOPS-1:0]       redir_q;
   logic [NOPS*IDX_W-1:0] base_q;
   logic [NOPS*IDX_W-1:0] scal_q;
   logic [NOPS*IDX_W-1:0] scal_d;
   logic [NOPS-1:0]       ovf_vec;
   logic                  any_ovf;

   assign accept  = in_valid && in_ready;
   assign count   = (|in_redir) ? in_vl : VL_W'(1);
   assign any_ovf = |ovf_vec;

   genvar g;
   generate
      for (g = 0; g < NOPS; g++) begin : g_op
         vxs_idx_map #(.ARCH_W(ARCH_W), .IDX_W(IDX_W)) u_map (
            .is_fp (in_fp[g]),
            .arch  (in_arch[g*ARCH_W +: ARCH_W]),
            .phys  (scal_d[g*IDX_W +: IDX_W])
         );

         vxs_elem_gen #(.IDX_W(IDX_W), .VL_W(VL_W)) u_gen (
            .redir      (redir_q[g]),
            .base       (base_q[g*IDX_W +: IDX_W]),
            .scalar_idx (scal_q[g*IDX_W +: IDX_W]),
            .elem       (out_elem),
            .idx        (out_idx[g*IDX_W +: IDX_W]),
            .ovf        (ovf_vec[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_q <= '0;
         base_q  <= '0;
         scal_q  <= '0;
      end else if (accept) begin
         redir_q <= in_redir;
         base_q  <= in_base;
         scal_q  <= scal_d;
      end
   end

   vxs_seq_ctrl #(.VL_W(VL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .count     (count),
      .any_ovf   (any_ovf),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .elem      (out_elem),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_err   (out_err)
   );

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!out_valid && !out_err)); // R10
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_elem))); // R10
   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !$past(in_ready)) |-> 1'b1 ##0 (!out_valid)); // R10
   AST_FIRST_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && count != '0) |=> ((out_valid || out_err) && out_elem == '0)); // R4
endmodule

// File: tb/vxs_expander_tb.sv
module vxs_expander_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NOPS = 3, ARCH_W = 5, IDX_W = 7, VL_W = 7;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, out_ready = 0;
   logic in_ready, out_valid, out_last, out_err;
   logic [VL_W-1:0]        in_vl = '0;
   logic [NOPS-1:0]        in_fp = '0, in_redir = '0;
   logic [NOPS*ARCH_W-1:0] in_arch = '0;
   logic [NOPS*IDX_W-1:0]  in_base = '0;
   logic [NOPS*IDX_W-1:0]  out_idx;
   logic [VL_W-1:0]        out_elem;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vxs_expander #(.NOPS(NOPS), .ARCH_W(ARCH_W), .IDX_W(IDX_W), .VL_W(VL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_vl(in_vl), .in_fp(in_fp), .in_arch(in_arch), .in_redir(in_redir),
      .in_base(in_base), .out_valid(out_valid), .out_ready(out_ready),
      .out_idx(out_idx), .out_elem(out_elem), .out_last(out_last), .out_err(out_err));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_idx(input int g, input int k);
      int b;
      b = int'(in_base[g*IDX_W +: IDX_W]);
      if (!in_redir[g]) return in_fp[g] ? 32 + int'(in_arch[g*ARCH_W +: ARCH_W])
                                        : int'(in_arch[g*ARCH_W +: ARCH_W]);
      if (b == 0) return 0;
      return b + k;
   endfunction

   function automatic int exp_count();
      return (|in_redir) ? int'(in_vl) : 1;
   endfunction

   function automatic int exp_ovf_at();
      for (int k = 0; k < exp_count(); k++)
         for (int g = 0; g < NOPS; g++)
            if (in_redir[g] && in_base[g*IDX_W +: IDX_W] != 0 && exp_idx(g, k) > 127) return k;
      return exp_count();
   endfunction

   function automatic string tag_of(input int g);
      if (!in_redir[g]) return in_fp[g] ? "R2/R5 fp" : "R2/R5 int";
      if (in_base[g*IDX_W +: IDX_W] == 0) return "R9";
      return "R3/R4";
   endfunction

   task automatic run_instr();
      int cnt, ovf_at, n_exp, k, guard;
      bit exp_err, got_err, done, stall;
      logic [NOPS*IDX_W-1:0] held;
      cnt = exp_count(); ovf_at = exp_ovf_at();
      n_exp = (ovf_at < cnt) ? ovf_at : cnt;
      exp_err = (ovf_at < cnt);
      @(negedge clk);
      chk(in_ready == 1, "R10 ready before issue", int'(in_ready), 1);
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      k = 0; got_err = 0; done = 0; stall = 0; guard = 0; held = '0;
      while (!done) begin
         out_ready = ($urandom % 4) != 0;
         if (out_err) begin
            got_err = 1;
            chk(out_valid == 0, "R8 no valid with err", int'(out_valid), 0);
            chk(k == ovf_at, "R8 err position", k, ovf_at);
            stall = 0;
         end else if (out_valid) begin
            chk(in_ready == 0, "R10 busy", int'(in_ready), 0);
            if (stall) chk(out_idx == held, "R10 hold", int'(out_idx), int'(held));
            chk(int'(out_elem) == k, "R4 elem", int'(out_elem), k);
            chk(out_last == (k == cnt - 1), "R11 last", int'(out_last), int'(k == cnt - 1));
            for (int g = 0; g < NOPS; g++)
               chk(int'(out_idx[g*IDX_W +: IDX_W]) == exp_idx(g, k), tag_of(g),
                   int'(out_idx[g*IDX_W +: IDX_W]), exp_idx(g, k));
            stall = !out_ready; held = out_idx;
            if (out_ready) k++;
         end else if (in_ready) begin
            done = 1;
         end
         if (!done) begin
            @(negedge clk);
            guard++;
            if (guard > 2000) begin
               chk(0, "R10 drain timeout", guard, 0);
               done = 1;
            end
         end
      end
      chk(k == n_exp, "R6/R7/R8 element count", k, n_exp);
      chk(got_err == exp_err, "R8 err seen", int'(got_err), int'(exp_err));
   endtask

   task automatic set_op(input int g, input bit fp, input int arch, input bit rd, input int base);
      in_fp[g] = fp; in_redir[g] = rd;
      in_arch[g*ARCH_W +: ARCH_W] = ARCH_W'(arch);
      in_base[g*IDX_W +: IDX_W] = IDX_W'(base);
   endtask

   function automatic int pick_base();
      case ($urandom % 4)
         0: return 28 + ($urandom % 6);
         1: return 118 + ($urandom % 10);
         2: return 0;
         default: return $urandom % 128;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(in_ready == 1, "R1 ready", int'(in_ready), 1);
      chk(out_valid == 0, "R1 valid", int'(out_valid), 0);
      chk(out_err == 0, "R1 err", int'(out_err), 0);
      rst_n = 1;
      // R3: run crossing from integer into fp range, shared offset with a second redirected op
      in_vl = 7'd4; set_op(0, 0, 1, 1, 30); set_op(1, 0, 2, 1, 64); set_op(2, 1, 3, 0, 0);
      run_instr();
      // R2: fp and int scalar mapping, no redirect -> one element (R7)
      in_vl = 7'd9; set_op(0, 1, 31, 0, 0); set_op(1, 0, 17, 0, 0); set_op(2, 1, 0, 0, 0);
      run_instr();
      // R6: vl zero
      in_vl = 7'd0; set_op(0, 0, 5, 1, 40); set_op(1, 0, 6, 0, 0); set_op(2, 0, 7, 0, 0);
      run_instr();
      chk(in_ready == 1 && out_valid == 0, "R6 idle after vl0", int'(out_valid), 0);
      // R8: overflow at element 3
      in_vl = 7'd5; set_op(0, 0, 1, 1, 125); set_op(1, 0, 2, 1, 10); set_op(2, 1, 4, 0, 0);
      run_instr();
      // R9: base zero redirected
      in_vl = 7'd3; set_op(0, 0, 0, 1, 0); set_op(1, 0, 9, 1, 50); set_op(2, 0, 0, 0, 0);
      run_instr();
      // R8: overflow on first element is impossible (base<=127); boundary at 127 exactly
      in_vl = 7'd1; set_op(0, 0, 3, 1, 127); set_op(1, 0, 3, 0, 0); set_op(2, 0, 3, 0, 0);
      run_instr();
      for (int n = 0; n < 300; n++) begin
         in_vl = VL_W'(($urandom % 8 == 0) ? ($urandom % 40) : ($urandom % 9));
         for (int g = 0; g < NOPS; g++)
            set_op(g, $urandom % 2, $urandom % 32, ($urandom % 3) != 0, pick_base());
         run_instr();
      end
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule